// File: doc/BRIEF.md
# Open-drain repeater channel direction control

This block is the digital control core for one line (clock or data) of a bidirectional buffer that joins two open-drain bus segments, side A and side B. Each side gives the block a sensed input and takes a pull-down request from it. The block decides which side started a low and copies that low to the other side. It then releases the two pull-downs in an order that cannot leave the channel holding itself low. Arbitration and clock stretching work through the repeater because of this ordering.

Side A is sensed as a plain high or low. Side B is sensed as one of three levels: high, a "buffer level" low, or a hard low. The buffer level is the shallow low that the block's own B pull-down produces. The block never treats it as a reason to drive side A, with one exception: the first falling edge seen from idle. A low from side A holds the B pull-down on only while A stays low. A low from side B turns the A pull-down on. When the hard low from B goes away, the A pull-down is released first. The B pull-down then holds B at the buffer level until side A has returned high, which gives a plateau on B. A connect input gates the whole channel.

Top module: `odrep_channel`

## Requirements
- R1: During and right after reset both pull-down outputs are off.
- R2: In any cycle where `link_en_i` is low, both pull-downs are off after the next clock edge, whatever the inputs are.
- R3: While idle (both pull-downs off) and connected, a low on `a_in_i` turns `b_drv_o` on after the next edge, with `a_drv_o` off.
- R4: While A leads, `b_drv_o` turns off one edge after `a_in_i` returns high, unless B shows a hard low at that time.
- R5: While idle, connected and with `a_in_i` high, any low on B turns `a_drv_o` on after the next edge. The B level is encoded on `b_lvl_i`: 2'b00 high, 2'b01 buffer level, 2'b10 or 2'b11 hard low.
- R6: While A leads, a buffer-level B input never turns `a_drv_o` on.
- R7: While B leads, `a_drv_o` stays on as long as B is a hard low. It ignores `a_in_i`, which its own pull-down holds low. At the first edge where B is not a hard low, `a_drv_o` goes off and `b_drv_o` comes on.
- R8: After a B-led low is released, `b_drv_o` stays on while `a_in_i` is low. It goes off one edge after `a_in_i` is high.
- R9: A B fall that never reaches a hard low gives a one-cycle pulse on `a_drv_o`. The B plateau hold follows, and the channel then returns to idle.
- R10: If A is low and B is a hard low in the same idle cycle, A is taken as the leader.
- R11: If B shows a hard low at the edge where a low led by A is released, `a_drv_o` turns on at that edge. This carries clock stretching and arbitration from B over to A.
- R12: The two pull-downs are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| link_en_i | input | 1 | connect gate; low forces the channel idle |
| a_in_i | input | 1 | sensed A line, 1 = high |
| b_lvl_i | input | 2 | sensed B level: 00 high, 01 buffer level, 1x hard low |
| a_drv_o | output | 1 | A pull-down request, 1 = pull low |
| b_drv_o | output | 1 | B pull-down request, 1 = pull to buffer level |

## Verification
Each pull-down output is a flop loaded from the next-state decode. Every response therefore shows up exactly one clock edge after the inputs that cause it, and never in the same cycle. The bench changes inputs on the falling edge, lets one rising edge pass, and samples 1 ns after it. Each check looks at the response to the inputs applied just before that edge. The line levels are rebuilt as wired-AND from the block's own registered outputs, so the self-induced lows (A held by `a_drv_o`, B at the buffer level under `b_drv_o`) come back one cycle later, as they would on a real bus.

// File: rtl/odrep_pkg.sv
package odrep_pkg;
  localparam int unsigned BLVL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_A_LEAD = 2'd1,
    ST_B_LEAD = 2'd2,
    ST_B_HOLD = 2'd3
  } rep_state_e;

  typedef struct packed {
    logic hard;
    logic any_low;
  } b_sense_t;
endpackage

// File: rtl/odrep_bsense.sv
module odrep_bsense
  import odrep_pkg::*;
(
  input  logic [BLVL_W-1:0] b_lvl_i,
  output b_sense_t          sense_o
);
  // msb marks an external hard low; lsb the buffer-level plateau
  always_comb begin
    sense_o.hard    = b_lvl_i[BLVL_W-1];
    sense_o.any_low = |b_lvl_i;
  end
endmodule

// File: rtl/odrep_fsm.sv
module odrep_fsm
  import odrep_pkg::*;
(
  input  rep_state_e st_i,
  input  logic       en_i,
  input  logic       a_high_i,
  input  b_sense_t   bs_i,
  output rep_state_e st_o
);
  always_comb begin
    st_o = st_i;
    if (!en_i) begin
      st_o = ST_IDLE;
    end else begin
      unique case (st_i)
        ST_IDLE: begin
          if (!a_high_i)          st_o = ST_A_LEAD;  // A wins a tie
          else if (bs_i.any_low)  st_o = ST_B_LEAD;  // first fall: any low
        end
        ST_A_LEAD: begin
          if (a_high_i) st_o = bs_i.hard ? ST_B_LEAD : ST_IDLE;
        end
        ST_B_LEAD: begin
          if (!bs_i.hard) st_o = ST_B_HOLD;          // later lows need hard
        end
        ST_B_HOLD: begin
          if (a_high_i) st_o = ST_IDLE;
        end
        default: st_o = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/odrep_drvdec.sv
module odrep_drvdec
  import odrep_pkg::*;
(
  input  rep_state_e st_i,
  output logic       a_pull_o,
  output logic       b_pull_o
);
  always_comb begin
    a_pull_o = (st_i == ST_B_LEAD);
    b_pull_o = (st_i == ST_A_LEAD) || (st_i == ST_B_HOLD);
  end
endmodule

// File: rtl/odrep_channel.sv
module odrep_channel
  import odrep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_en_i,
  input  logic              a_in_i,
  input  logic [BLVL_W-1:0] b_lvl_i,
  output logic              a_drv_o,
  output logic              b_drv_o
);
  rep_state_e st_q, st_d;
  b_sense_t   bs;
  logic       a_pull_d, b_pull_d;

  odrep_bsense u_bsense (
    .b_lvl_i (b_lvl_i),
    .sense_o (bs)
  );

  odrep_fsm u_fsm (
    .st_i     (st_q),
    .en_i     (link_en_i),
    .a_high_i (a_in_i),
    .bs_i     (bs),
    .st_o     (st_d)
  );

  odrep_drvdec u_dec (
    .st_i     (st_d),
    .a_pull_o (a_pull_d),
    .b_pull_o (b_pull_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      a_drv_o <= 1'b0;
      b_drv_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      a_drv_o <= a_pull_d;
      b_drv_o <= b_pull_d;
    end
  end
endmodule

// File: rtl/odrep_channel_chk.sv
module odrep_channel_chk
  import odrep_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              link_en_i,
  input logic              a_in_i,
  input logic [BLVL_W-1:0] b_lvl_i,
  input logic              a_drv_o,
  input logic              b_drv_o,
  input rep_state_e        st_q
);
  logic idle;
  assign idle = !a_drv_o && !b_drv_o;

  a_r12_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_drv_o && b_drv_o));

  a_r2_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_en_i |=> (!a_drv_o && !b_drv_o));

  a_r3_a_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && idle && !a_in_i) |=> (b_drv_o && !a_drv_o));

  a_r5_b_leads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && idle && a_in_i && (b_lvl_i != '0)) |=> a_drv_o);

  a_r7_handover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && a_drv_o && !b_lvl_i[BLVL_W-1]) |=> (!a_drv_o && b_drv_o));

  a_r8_plateau: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_en_i && st_q == ST_B_HOLD && !a_in_i) |=> b_drv_o);
endmodule

bind odrep_channel odrep_channel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .link_en_i (link_en_i),
  .a_in_i    (a_in_i),
  .b_lvl_i   (b_lvl_i),
  .a_drv_o   (a_drv_o),
  .b_drv_o   (b_drv_o),
  .st_q      (st_q)
);

// File: tb/odrep_channel_test.sv
`timescale 1ns/1ps
module odrep_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       a_ext = 1'b1;     // external A level, 1 = released
  logic [1:0] b_ext = 2'd0;     // 0 released, 1 weak (buffer-level) low, 2 hard low
  logic       a_in;
  logic [1:0] b_lvl;
  logic       a_drv, b_drv;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus model
  assign a_in  = a_ext & ~a_drv;
  assign b_lvl = (b_ext == 2'd2) ? 2'b10 : ((b_ext == 2'd1 || b_drv) ? 2'b01 : 2'b00);

  odrep_channel uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .link_en_i (en),
    .a_in_i    (a_in),
    .b_lvl_i   (b_lvl),
    .a_drv_o   (a_drv),
    .b_drv_o   (b_drv)
  );

  // {en, a_ext, b_ext[1:0], exp_a_drv, exp_b_drv}
  localparam int NV = 21;
  localparam logic [5:0] VEC [NV] = '{
    6'b1_1_00_00,  // 0  R1 idle stays idle
    6'b1_0_00_01,  // 1  R3 A low -> B pulled
    6'b1_0_01_01,  // 2  R6 buffer level ignored while A leads
    6'b1_1_01_00,  // 3  R4 A high -> release
    6'b1_1_00_00,  // 4  R4 idle
    6'b1_1_10_10,  // 5  R5 B hard -> A pulled
    6'b1_0_10_10,  // 6  R7 held while hard
    6'b1_0_01_01,  // 7  R7 handover to plateau
    6'b1_0_01_01,  // 8  R8 plateau while A low
    6'b1_1_01_00,  // 9  R8 A high -> release
    6'b1_1_00_00,  // 10 R8 idle
    6'b1_0_10_01,  // 11 R10 tie -> A leads
    6'b1_1_10_10,  // 12 R11 stretch carried to A
    6'b1_1_00_01,  // 13 R7 hard gone -> plateau
    6'b1_1_00_00,  // 14 R8 A high -> idle
    6'b0_0_10_00,  // 15 R2 gated
    6'b0_0_00_00,  // 16 R2 gated
    6'b1_1_00_00,  // 17 R2 idle after gate
    6'b1_0_00_01,  // 18 R3 A leads again
    6'b0_0_00_00,  // 19 R2 gate drops mid-low
    6'b1_1_00_00   // 20 R2 idle
  };
  localparam int VREQ [NV] = '{1,3,6,4,4,5,7,7,8,8,8,10,11,7,8,2,2,2,3,2,2};

  task automatic check(input int req, input logic ea, input logic eb);
    n_chk++;
    if (a_drv !== ea || b_drv !== eb) begin
      n_fail++;
      $display("FAIL R%0d: a_drv=%b b_drv=%b expected a_drv=%b b_drv=%b",
               req, a_drv, b_drv, ea, eb);
    end
  endtask

  task automatic step(input logic e, input logic a, input logic [1:0] b);
    @(negedge clk);
    en = e; a_ext = a; b_ext = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    check(1, 1'b0, 1'b0);               // R1 during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    en    = 1'b1;
    @(posedge clk); #1;
    check(1, 1'b0, 1'b0);               // R1 after reset

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3:2]);
      check(VREQ[i], VEC[i][1], VEC[i][0]);
    end

    // R9: weak B fall that never reaches a hard low
    step(1'b1, 1'b1, 2'd1);
    check(9, 1'b1, 1'b0);               // A pulled for one cycle
    step(1'b1, 1'b1, 2'd0);
    check(9, 1'b0, 1'b1);               // A released, B plateau
    step(1'b1, 1'b1, 2'd0);
    check(9, 1'b0, 1'b0);               // back to idle

    // R12: both pull-downs never on together over a busy pattern
    for (int k = 0; k < 40; k++) begin
      step(1'b1, k[0] ^ k[2], 2'((k * 7) % 3));
      n_chk++;
      if (a_drv && b_drv) begin
        n_fail++;
        $display("FAIL R12: a_drv=%b b_drv=%b expected not both 1", a_drv, b_drv);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule